// File: doc/BRIEF.md
# Handshake Link Utilization Monitor

A passive observer for a single VALID/READY channel. It only samples the two handshake wires and never drives them. A one-cycle start pulse opens an observation window of a programmable number of cycles. During the window it counts elapsed cycles, cycles with the producer offering data, cycles with the consumer accepting, completed beats, and stall cycles. It also tracks the longest unbroken run of stall cycles. When the window closes, every counter freezes and a done flag is raised. The flag stays high until the next start pulse.

While done is high, the monitor reports the link utilization as a whole percentage. It names the side that limits the link: a starved producer or a back-pressuring consumer. It classifies the stalls in three ways:
- a consumer that toggles acceptance on every cycle while data is always offered, which is the mark of a half-rate pipeline stage;
- stalls that cluster into long runs, classed as transient, which a buffer can absorb;
- stalls that are spread thinly, classed as sustained, which point at a slow consumer.

An optional full-rate check mode raises a sticky failure flag as soon as any offered beat is refused.

Top module: `link_util_mon`

## Requirements
- R1: A start pulse clears all counters and flags, latches the window length, threshold-independent mode bit and begins observation on the next cycle. Exactly N cycles are observed, and a window length of 0 behaves as 1. busy_o is high during observation and done_o goes high after the N-th cycle. A start pulse always takes priority, including on the window's last cycle.
- R2: While done_o is high and no start arrives, all counters hold their values regardless of valid_i and ready_i.
- R3: beat_cnt_o counts window cycles with valid_i=1 and ready_i=1. stall_cnt_o counts window cycles with valid_i=1 and ready_i=0.
- R4: vld_cnt_o counts window cycles with valid_i=1. rdy_cnt_o counts window cycles with ready_i=1.
- R5: While done_o is high, util_pct_o equals floor(100 × beat_cnt_o / cyc_cnt_o). Otherwise it is 0.
- R6: While done_o is high, prod_starved_o is 1 when vld_cnt_o < rdy_cnt_o, and cons_bp_o is 1 when rdy_cnt_o < vld_cnt_o. When the two counts are equal, neither flag is set.
- R7: While done_o is high, half_rate_o is 1 when the window has at least 2 cycles, valid_i was 1 on every window cycle, and ready_i differed from its previous value on every window cycle after the first.
- R8: max_run_o is the longest run of consecutive stall cycles in the window. While done_o is high and stall_cnt_o is nonzero, transient_o is set if max_run_o ≥ run_thresh_i, and sustained_o is set otherwise. With no stalls, both are 0.
- R9: When full_rate_mode_i was 1 at start, full_rate_fail_o becomes 1 one cycle after any window cycle with valid_i=1 and ready_i=0. It then stays 1 until the next start.
- R10: All counters and max_run_o saturate at their all-ones value and never wrap.
- R11: A synchronous reset clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Observed producer VALID |
| ready_i | input | 1 | Observed consumer READY |
| start_i | input | 1 | Start or restart an observation window |
| win_len_i | input | WIN_W | Window length in cycles, latched at start |
| run_thresh_i | input | CNT_W | Stall run length that marks stalls as transient |
| full_rate_mode_i | input | 1 | Enable the full-rate check, latched at start |
| busy_o | output | 1 | Window in progress |
| done_o | output | 1 | Window finished, results frozen |
| cyc_cnt_o | output | CNT_W | Observed cycles |
| vld_cnt_o | output | CNT_W | Cycles with VALID high |
| rdy_cnt_o | output | CNT_W | Cycles with READY high |
| beat_cnt_o | output | CNT_W | Completed beats |
| stall_cnt_o | output | CNT_W | Stall cycles |
| max_run_o | output | CNT_W | Longest stall run |
| util_pct_o | output | 7 | Utilization percentage |
| prod_starved_o | output | 1 | Producer is the bottleneck |
| cons_bp_o | output | 1 | Consumer is the bottleneck |
| half_rate_o | output | 1 | Alternating-READY half-rate stage suspect |
| sustained_o | output | 1 | Stalls are spread thinly |
| transient_o | output | 1 | Stalls form a long run |
| full_rate_fail_o | output | 1 | Full-rate check saw a refused beat |

## Verification
Two events can land on the same clock edge: a restart pulse and the last cycle of the current window. The question is whether the monitor closes that window or opens a new one. The bench provokes this by asserting start together with the final window cycle's handshake values. It expects done to stay low, the counters to read zero, and a following short window to count only its own cycles. A second overlap happens when a stall on the last window cycle extends the longest run. The all-refused window checks this, and max_run_o must equal the full window length there.

// File: rtl/lum_pkg.sv
package lum_pkg;

  function automatic logic is_beat(input logic v, input logic r);
    return v & r;
  endfunction

  function automatic logic is_stall(input logic v, input logic r);
    return v & ~r;
  endfunction

  // floor(100 * beats / cycles), zero for an empty window
  function automatic logic [6:0] util_pct(input int unsigned beats,
                                          input int unsigned cycles);
    int unsigned q;
    if (cycles == 0) return 7'd0;
    q = (beats * 100) / cycles;
    return 7'(q);
  endfunction

  typedef struct packed {
    logic prod_starved;
    logic cons_bp;
    logic half_rate;
    logic sustained;
    logic transient;
  } lum_flags_t;

endpackage

// File: rtl/lum_sat_cnt.sv
module lum_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAXV = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clr)                 cnt_o <= '0;
    else if (inc && cnt_o != MAXV)  cnt_o <= cnt_o + 1'b1;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (cnt_o == MAXV && !clr) |=> (cnt_o == MAXV)); // R10
endmodule

// File: rtl/lum_window_ctl.sv
module lum_window_ctl #(
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic             fr_mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             fr_mode_o
);
  logic [WIN_W-1:0] win_q;
  logic [WIN_W-1:0] wcnt;
  logic [WIN_W:0]   wnext;
  logic             last_cyc;

  assign wnext    = {1'b0, wcnt} + (WIN_W+1)'(1);
  assign last_cyc = busy_o && (wnext >= {1'b0, win_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q <= '0; wcnt <= '0; busy_o <= 1'b0; done_o <= 1'b0; fr_mode_o <= 1'b0;
    end else if (start_i) begin
      win_q <= win_len_i; wcnt <= '0; busy_o <= 1'b1; done_o <= 1'b0;
      fr_mode_o <= fr_mode_i;
    end else if (busy_o) begin
      wcnt <= wnext[WIN_W-1:0];
      if (last_cyc) begin
        busy_o <= 1'b0;
        done_o <= 1'b1;
      end
    end
  end

  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(busy_o && done_o)); // R1
  AST_WINDOW_CLOSES: assert property (@(posedge clk) disable iff (rst)
    (last_cyc && !start_i) |=> (done_o && !busy_o)); // R1
  AST_START_OPENS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (busy_o && !done_o)); // R1
endmodule

// File: rtl/lum_stall_tracker.sv
module lum_stall_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             sample,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             fr_mode_i,
  output logic [CNT_W-1:0] max_run_o,
  output logic             alt_ok_o,
  output logic             fr_fail_o
);
  import lum_pkg::*;
  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cur_run, cur_next;
  logic             stall_ev;
  logic             seen, prev_rdy;

  assign stall_ev = sample && is_stall(valid_i, ready_i);
  assign cur_next = is_stall(valid_i, ready_i)
                    ? ((cur_run == MAXV) ? cur_run : cur_run + 1'b1) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_run <= '0; max_run_o <= '0; alt_ok_o <= 1'b0; seen <= 1'b0;
      prev_rdy <= 1'b0; fr_fail_o <= 1'b0;
    end else if (clr) begin
      cur_run <= '0; max_run_o <= '0; alt_ok_o <= 1'b1; seen <= 1'b0;
      prev_rdy <= 1'b0; fr_fail_o <= 1'b0;
    end else if (sample) begin
      cur_run <= cur_next;
      if (stall_ev && cur_next > max_run_o) max_run_o <= cur_next;
      if (!valid_i || (seen && ready_i == prev_rdy)) alt_ok_o <= 1'b0;
      seen     <= 1'b1;
      prev_rdy <= ready_i;
      if (stall_ev && fr_mode_i) fr_fail_o <= 1'b1;
    end
  end

  AST_FULL_RATE_FAIL: assert property (@(posedge clk) disable iff (rst)
    (stall_ev && fr_mode_i && !clr) |=> fr_fail_o); // R9
  AST_RUN_BOUND: assert property (@(posedge clk) disable iff (rst)
    cur_run <= max_run_o); // R8
endmodule

// File: rtl/lum_classify.sv
module lum_classify #(
  parameter int CNT_W = 16
) (
  input  logic             done_i,
  input  logic [CNT_W-1:0] cyc_i,
  input  logic [CNT_W-1:0] vld_i,
  input  logic [CNT_W-1:0] rdy_i,
  input  logic [CNT_W-1:0] beat_i,
  input  logic [CNT_W-1:0] stall_i,
  input  logic [CNT_W-1:0] max_run_i,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             alt_ok_i,
  output logic [6:0]       util_o,
  output lum_pkg::lum_flags_t flags_o
);
  import lum_pkg::*;

  logic any_stall, long_run;
  assign any_stall = (stall_i != '0);
  assign long_run  = (max_run_i >= thresh_i);

  always_comb begin
    flags_o = '0;
    util_o  = '0;
    if (done_i) begin
      util_o               = util_pct(32'(beat_i), 32'(cyc_i));
      flags_o.prod_starved = (vld_i < rdy_i);
      flags_o.cons_bp      = (rdy_i < vld_i);
      flags_o.half_rate    = alt_ok_i && (cyc_i >= CNT_W'(2));
      flags_o.transient    = any_stall && long_run;
      flags_o.sustained    = any_stall && !long_run;
    end
  end
endmodule

// File: rtl/link_util_mon.sv
module link_util_mon #(
  parameter int CNT_W = 16,
  parameter int WIN_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid_i,
  input  logic             ready_i,
  input  logic             start_i,
  input  logic [WIN_W-1:0] win_len_i,
  input  logic [CNT_W-1:0] run_thresh_i,
  input  logic             full_rate_mode_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cyc_cnt_o,
  output logic [CNT_W-1:0] vld_cnt_o,
  output logic [CNT_W-1:0] rdy_cnt_o,
  output logic [CNT_W-1:0] beat_cnt_o,
  output logic [CNT_W-1:0] stall_cnt_o,
  output logic [CNT_W-1:0] max_run_o,
  output logic [6:0]       util_pct_o,
  output logic             prod_starved_o,
  output logic             cons_bp_o,
  output logic             half_rate_o,
  output logic             sustained_o,
  output logic             transient_o,
  output logic             full_rate_fail_o
);
  import lum_pkg::*;
  localparam int NCNT = 5;

  // named internal events for the assertions
  logic       fr_mode_q, alt_ok;
  logic       beat_ev, stall_ev;
  lum_flags_t flags;
  logic [NCNT-1:0]       inc_vec;
  logic [CNT_W-1:0]      cnt_arr [NCNT];

  assign beat_ev  = is_beat(valid_i, ready_i);
  assign stall_ev = is_stall(valid_i, ready_i);
  assign inc_vec  = {stall_ev, beat_ev, ready_i, valid_i, 1'b1};

  lum_window_ctl #(.WIN_W(WIN_W)) win_i (
    .clk(clk), .rst(rst), .start_i(start_i), .win_len_i(win_len_i),
    .fr_mode_i(full_rate_mode_i), .busy_o(busy_o), .done_o(done_o),
    .fr_mode_o(fr_mode_q));

  for (genvar g = 0; g < NCNT; g++) begin : g_cnt
    lum_sat_cnt #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst(rst), .clr(start_i), .inc(busy_o && inc_vec[g]),
      .cnt_o(cnt_arr[g]));
  end

  assign cyc_cnt_o   = cnt_arr[0];
  assign vld_cnt_o   = cnt_arr[1];
  assign rdy_cnt_o   = cnt_arr[2];
  assign beat_cnt_o  = cnt_arr[3];
  assign stall_cnt_o = cnt_arr[4];

  lum_stall_tracker #(.CNT_W(CNT_W)) trk_i (
    .clk(clk), .rst(rst), .clr(start_i), .sample(busy_o),
    .valid_i(valid_i), .ready_i(ready_i), .fr_mode_i(fr_mode_q),
    .max_run_o(max_run_o), .alt_ok_o(alt_ok), .fr_fail_o(full_rate_fail_o));

  lum_classify #(.CNT_W(CNT_W)) cls_i (
    .done_i(done_o), .cyc_i(cyc_cnt_o), .vld_i(vld_cnt_o), .rdy_i(rdy_cnt_o),
    .beat_i(beat_cnt_o), .stall_i(stall_cnt_o), .max_run_i(max_run_o),
    .thresh_i(run_thresh_i), .alt_ok_i(alt_ok), .util_o(util_pct_o),
    .flags_o(flags));

  assign prod_starved_o = flags.prod_starved;
  assign cons_bp_o      = flags.cons_bp;
  assign half_rate_o    = flags.half_rate;
  assign sustained_o    = flags.sustained;
  assign transient_o    = flags.transient;

  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (cyc_cnt_o == '0 && beat_cnt_o == '0 && !full_rate_fail_o)); // R1
  AST_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (done_o && !start_i) |=> ($stable(cyc_cnt_o) && $stable(beat_cnt_o)
                              && $stable(stall_cnt_o))); // R2
  AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (rst)
    (beat_cnt_o <= vld_cnt_o) && (beat_cnt_o <= rdy_cnt_o)); // R3
  AST_BOTTLENECK_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(prod_starved_o && cons_bp_o)); // R6
  AST_CLASS_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(sustained_o && transient_o)); // R8
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!busy_o && !done_o && cyc_cnt_o == '0 && max_run_o == '0)); // R11
endmodule

// File: tb/link_util_mon_tb_top.sv
module link_util_mon_tb_top;
  localparam int CW = 8;
  localparam int WW = 10;

  logic clk = 1'b0;
  logic rst, valid, ready, start, frm;
  logic [WW-1:0] win;
  logic [CW-1:0] thr;
  logic busy, done, ps, cb, hr, su, tr, ff;
  logic [CW-1:0] cyc, vld, rdy, beat, stl, mrun;
  logic [6:0] util;

  int n_checks = 0;
  int n_fail   = 0;

  always #4 clk = ~clk;

  link_util_mon #(.CNT_W(CW), .WIN_W(WW)) dut_i (
    .clk(clk), .rst(rst), .valid_i(valid), .ready_i(ready), .start_i(start),
    .win_len_i(win), .run_thresh_i(thr), .full_rate_mode_i(frm),
    .busy_o(busy), .done_o(done), .cyc_cnt_o(cyc), .vld_cnt_o(vld),
    .rdy_cnt_o(rdy), .beat_cnt_o(beat), .stall_cnt_o(stl), .max_run_o(mrun),
    .util_pct_o(util), .prod_starved_o(ps), .cons_bp_o(cb), .half_rate_o(hr),
    .sustained_o(su), .transient_o(tr), .full_rate_fail_o(ff));

  typedef struct packed {
    logic [9:0]  win;
    logic [15:0] vm;
    logic [15:0] rm;
    logic [7:0]  th;
    logic        fr;
    logic [9:0]  e_cyc;
    logic [7:0]  e_vld, e_rdy, e_beat, e_stall, e_run;
    logic [6:0]  e_util;
    logic [5:0]  e_flg; // {starved, backpressure, half, sustained, transient, fr_fail}
  } vec_t;

  localparam vec_t VECS [9] = '{
    '{10'd8,  16'hFFFF, 16'h5555, 8'd2, 1'b0, 10'd8,  8'd8,  8'd4,  8'd4,  8'd4, 8'd1, 7'd50,  6'b011100},
    '{10'd16, 16'hFFFF, 16'hFFFF, 8'd2, 1'b1, 10'd16, 8'd16, 8'd16, 8'd16, 8'd0, 8'd0, 7'd100, 6'b000000},
    '{10'd16, 16'hFFFF, 16'hF0FF, 8'd3, 1'b1, 10'd16, 8'd16, 8'd12, 8'd12, 8'd4, 8'd4, 7'd75,  6'b010011},
    '{10'd12, 16'h0333, 16'hFFFF, 8'd2, 1'b0, 10'd12, 8'd6,  8'd12, 8'd6,  8'd0, 8'd0, 7'd50,  6'b100000},
    '{10'd10, 16'hFFFF, 16'h6DB6, 8'd2, 1'b0, 10'd10, 8'd10, 8'd6,  8'd6,  8'd4, 8'd1, 7'd60,  6'b010100},
    '{10'd4,  16'hFFFF, 16'hAAAA, 8'd1, 1'b0, 10'd4,  8'd4,  8'd2,  8'd2,  8'd2, 8'd1, 7'd50,  6'b011010},
    '{10'd0,  16'h0001, 16'h0001, 8'd2, 1'b0, 10'd1,  8'd1,  8'd1,  8'd1,  8'd0, 8'd0, 7'd100, 6'b000000},
    '{10'd9,  16'hFFFF, 16'h0000, 8'd4, 1'b1, 10'd9,  8'd9,  8'd0,  8'd0,  8'd9, 8'd9, 7'd0,   6'b010011},
    '{10'd7,  16'h0000, 16'h0000, 8'd2, 1'b0, 10'd7,  8'd0,  8'd0,  8'd0,  8'd0, 8'd0, 7'd0,   6'b000000}
  };

  task automatic chk(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic open_window(input int w, input int t, input logic m);
    @(negedge clk);
    start = 1'b1; win = WW'(w); thr = CW'(t); frm = m; valid = 1'b0; ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic drive_cycles(input int n, input logic v, input logic r);
    for (int i = 0; i < n; i++) begin
      valid = v; ready = r;
      @(negedge clk);
    end
    valid = 1'b0; ready = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; valid = 1'b0; ready = 1'b0; start = 1'b0; frm = 1'b0;
    win = '0; thr = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset busy", busy, 0);
    chk("R11 reset done", done, 0);
    chk("R11 reset cyc", cyc, 0);
    chk("R11 reset util", util, 0);

    // table walk
    foreach (VECS[k]) begin
      vec_t v;
      int n;
      v = VECS[k];
      n = (v.win == 0) ? 1 : int'(v.win);
      open_window(int'(v.win), int'(v.th), v.fr);
      chk("R1 busy after start", busy, 1);
      chk("R1 cleared after start", cyc, 0);
      for (int i = 0; i < n; i++) begin
        valid = v.vm[i % 16]; ready = v.rm[i % 16];
        @(negedge clk);
      end
      valid = 1'b0; ready = 1'b0;
      chk("R1 done", done, 1);
      chk("R1 busy cleared", busy, 0);
      chk("R1 cycles", cyc, v.e_cyc);
      chk("R4 valid count", vld, v.e_vld);
      chk("R4 ready count", rdy, v.e_rdy);
      chk("R3 beats", beat, v.e_beat);
      chk("R3 stalls", stl, v.e_stall);
      chk("R8 longest run", mrun, v.e_run);
      chk("R5 util", util, v.e_util);
      chk("R6 producer starved", ps, v.e_flg[5]);
      chk("R6 consumer backpressure", cb, v.e_flg[4]);
      chk("R7 half rate", hr, v.e_flg[3]);
      chk("R8 sustained", su, v.e_flg[2]);
      chk("R8 transient", tr, v.e_flg[1]);
      chk("R9 full rate fail", ff, v.e_flg[0]);
      // R2 frozen after done
      drive_cycles(3, 1'b1, 1'b0);
      chk("R2 frozen cycles", cyc, v.e_cyc);
      chk("R2 frozen stalls", stl, v.e_stall);
      chk("R2 done held", done, 1);
    end

    // R1 restart collides with last window cycle
    open_window(6, 2, 1'b0);
    drive_cycles(5, 1'b1, 1'b1);
    valid = 1'b1; ready = 1'b1; start = 1'b1; win = WW'(3);
    @(negedge clk);
    start = 1'b0;
    chk("R1 restart wins done", done, 0);
    chk("R1 restart busy", busy, 1);
    chk("R1 restart clears", beat, 0);
    drive_cycles(3, 1'b1, 1'b1);
    chk("R1 restart window done", done, 1);
    chk("R1 restart window cycles", cyc, 3);
    chk("R3 restart window beats", beat, 3);

    // R10 saturation: long full-rate window
    open_window(300, 2, 1'b1);
    drive_cycles(300, 1'b1, 1'b1);
    chk("R10 cycles saturate", cyc, 255);
    chk("R10 beats saturate", beat, 255);
    chk("R5 util after saturation", util, 100);
    chk("R9 no fail at full rate", ff, 0);

    // R10 saturation of stalls and run length
    open_window(300, 200, 1'b1);
    drive_cycles(300, 1'b1, 1'b0);
    chk("R10 stalls saturate", stl, 255);
    chk("R10 run saturates", mrun, 255);
    chk("R8 transient long run", tr, 1);
    chk("R9 fail on stall", ff, 1);

    // R9 fail visible mid-window, one cycle after the stall
    open_window(20, 2, 1'b1);
    drive_cycles(2, 1'b1, 1'b1);
    valid = 1'b1; ready = 1'b0;
    @(negedge clk);
    chk("R9 fail next cycle", ff, 1);
    chk("R1 still busy", busy, 1);

    // R11 reset mid-window
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R11 reset busy mid", busy, 0);
    chk("R11 reset fail flag", ff, 0);
    chk("R11 reset stalls", stl, 0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule